// File: doc/BRIEF.md
# Crossbar Barrel Shifter

This block moves a 32-bit word left or right by any distance from 0 to 31 in one combinational pass. The datapath is a square switch matrix. Every output bit is the OR of the input bits that reach it along the diagonals the control enables. A shift amount enables one diagonal. An output bit that no enabled diagonal reaches stays at 0, and that gives the zero fill of the logical shifts without any extra logic.

Rotate right by k enables two diagonals: the right-k diagonal and the left-(32−k) diagonal. Arithmetic right shift uses the same right diagonal as a logical right shift. A separate sign-fill mask, decoded from the amount, then ORs the sign bit into the vacated upper positions.

The block also returns the last bit shifted out as a carry. When the amount is zero it returns the carry input unchanged. The block sits in the operand path of a processor datapath, ahead of the adder.

Top module: `crossbarShifter`

## Requirements
- R1: With shiftKind 2'b00 (logical left), dataOut equals dataIn shifted toward bit 31 by shiftAmt, with the low shiftAmt bits filled with 0.
- R2: With shiftKind 2'b01 (logical right), dataOut equals dataIn shifted toward bit 0 by shiftAmt, with the top shiftAmt bits filled with 0.
- R3: With shiftKind 2'b10 (arithmetic right), dataOut equals dataIn shifted toward bit 0 by shiftAmt, with the top shiftAmt bits filled with dataIn[31].
- R4: With shiftKind 2'b11 (rotate right), bit j of dataOut equals bit (j+shiftAmt) mod 32 of dataIn, so no bit is lost.
- R5: When shiftAmt is 0, dataOut equals dataIn and carryOut equals carryIn for every shift kind.
- R6: When shiftAmt is k ≠ 0, carryOut is dataIn[32−k] for logical left, and dataIn[k−1] for logical right and for arithmetic right.
- R7: When shiftAmt is nonzero and the kind is rotate right, carryOut equals dataOut[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | 32 | Word to be shifted |
| shiftAmt | input | 5 | Shift distance, 0 to 31 |
| shiftKind | input | 2 | 00 left, 01 right, 10 arithmetic right, 11 rotate right |
| carryIn | input | 1 | Carry returned when shiftAmt is 0 |
| dataOut | output | 32 | Shifted word |
| carryOut | output | 1 | Last bit shifted out |

## Verification
The hardest cases to reach are the ones at the edges of the matrix. One is a rotate, where two diagonals meet and a fault in the complementary diagonal index shows only at one amount. The other is an arithmetic shift by 31, where the sign-fill mask covers every output bit except bit 0. The stimulus walks every shift kind at all 32 amounts. It uses data words whose bit patterns are asymmetric and whose sign bit takes both values, so each diagonal and each mask length is seen with ones on both sides of the split. The reference results come from the language's own shift operators.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int WORD_W = 32;
  localparam int AMT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;

  // strobes from the decode to the switch matrix
  typedef struct packed {
    logic [WORD_W-1:0] rightDiag;  // diagonal k: in[j+k] -> out[j]
    logic [WORD_W-1:0] leftDiag;   // diagonal k: in[j-k] -> out[j]
    logic [WORD_W-1:0] signMask;   // outputs that take the sign bit
    logic [WORD_W-1:0] carryTap;   // input bit returned as carry
    logic              useCarryIn;
  } xbar_ctrl_t;
endpackage

// File: rtl/xbarCtrl.sv
module xbarCtrl
  import shifter_pkg::*;
#(
  parameter int W  = WORD_W,
  localparam int AW = $clog2(W)
) (
  input  logic [AW-1:0] shiftAmt,
  input  logic [1:0]    shiftKind,
  output xbar_ctrl_t    ctrl
);
  logic [AW:0]   compAmt;
  logic [AW-1:0] lastOut;
  logic          amtZero;
  shift_kind_e   kind;

  always_comb begin
    kind    = shift_kind_e'(shiftKind);
    amtZero = (shiftAmt == '0);
    compAmt = (AW+1)'(W) - {1'b0, shiftAmt};
    lastOut = shiftAmt - AW'(1);

    ctrl            = '0;
    ctrl.useCarryIn = amtZero;
    unique case (kind)
      KIND_LSL: begin
        ctrl.leftDiag[shiftAmt] = 1'b1;
        if (!amtZero) ctrl.carryTap[compAmt[AW-1:0]] = 1'b1;
      end
      KIND_LSR: begin
        ctrl.rightDiag[shiftAmt] = 1'b1;
        if (!amtZero) ctrl.carryTap[lastOut] = 1'b1;
      end
      KIND_ASR: begin
        ctrl.rightDiag[shiftAmt] = 1'b1;
        ctrl.signMask            = ~({W{1'b1}} >> shiftAmt);
        if (!amtZero) ctrl.carryTap[lastOut] = 1'b1;
      end
      default: begin
        ctrl.rightDiag[shiftAmt] = 1'b1;
        if (!amtZero) begin
          ctrl.leftDiag[compAmt[AW-1:0]] = 1'b1;
          ctrl.carryTap[lastOut]         = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    // R1
    leftOnly_chk: assert (kind != KIND_LSL ||
                          ($onehot(ctrl.leftDiag) && ctrl.rightDiag == '0));
    // R4
    rotPair_chk: assert (kind != KIND_ROR || amtZero ||
                         ($countones(ctrl.rightDiag) + $countones(ctrl.leftDiag) == 2));
    // R6
    tapOne_chk: assert (amtZero || $onehot(ctrl.carryTap));
  end
endmodule

// File: rtl/xbarDatapath.sv
module xbarDatapath
  import shifter_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] dataIn,
  input  logic         carryIn,
  input  xbar_ctrl_t   ctrl,
  output logic [W-1:0] dataOut,
  output logic         carryOut
);
  logic [W-1:0] rTerm [W];
  logic [W-1:0] lTerm [W];

  for (genvar j = 0; j < W; j++) begin : g_out
    for (genvar k = 0; k < W; k++) begin : g_diag
      if (j + k < W) begin : g_r
        assign rTerm[j][k] = ctrl.rightDiag[k] & dataIn[j+k];
      end else begin : g_rz
        assign rTerm[j][k] = 1'b0;
      end
      if (j >= k) begin : g_l
        assign lTerm[j][k] = ctrl.leftDiag[k] & dataIn[j-k];
      end else begin : g_lz
        assign lTerm[j][k] = 1'b0;
      end
    end
    assign dataOut[j] = (|rTerm[j]) | (|lTerm[j]) | (ctrl.signMask[j] & dataIn[W-1]);
  end

  assign carryOut = ctrl.useCarryIn ? carryIn : |(dataIn & ctrl.carryTap);

  always_comb begin
    // R3
    signTop_chk: assert (ctrl.signMask == '0 || dataOut[W-1] == dataIn[W-1]);
  end
endmodule

// File: rtl/crossbarShifter.sv
module crossbarShifter
  import shifter_pkg::*;
#(
  parameter int W  = WORD_W,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  dataIn,
  input  logic [AW-1:0] shiftAmt,
  input  logic [1:0]    shiftKind,
  input  logic          carryIn,
  output logic [W-1:0]  dataOut,
  output logic          carryOut
);
  xbar_ctrl_t ctrl;

  xbarCtrl #(.W(W)) u_ctrl (
    .shiftAmt (shiftAmt),
    .shiftKind(shiftKind),
    .ctrl     (ctrl)
  );

  xbarDatapath #(.W(W)) u_dp (
    .dataIn  (dataIn),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .dataOut (dataOut),
    .carryOut(carryOut)
  );

  always_comb begin
    // R5
    passThru_chk: assert (shiftAmt != '0 || (dataOut == dataIn && carryOut == carryIn));
    // R4
    rotPopcnt_chk: assert (shiftKind != 2'b11 || $countones(dataOut) == $countones(dataIn));
    // R7
    rotCarry_chk: assert (shiftKind != 2'b11 || shiftAmt == '0 || carryOut == dataOut[W-1]);
    // R1
    lslFill_chk: assert (shiftKind != 2'b00 || (dataOut & ~({W{1'b1}} << shiftAmt)) == '0);
    // R2
    lsrFill_chk: assert (shiftKind != 2'b01 || (dataOut & ~({W{1'b1}} >> shiftAmt)) == '0);
  end
endmodule

// File: tb/crossbarShifter_test.sv
module crossbarShifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dataIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  shiftKind = '0;
  logic        carryIn = 1'b0;
  logic [31:0] dataOut;
  logic        carryOut;
  int          nChecks = 0;
  int          nFails = 0;
  int          cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  crossbarShifter uut (
    .dataIn(dataIn), .shiftAmt(shiftAmt), .shiftKind(shiftKind),
    .carryIn(carryIn), .dataOut(dataOut), .carryOut(carryOut)
  );

  // data, amount, kind, carry in, expected out, expected carry
  typedef struct packed {
    logic [31:0] d; logic [4:0] a; logic [1:0] k; logic ci;
    logic [31:0] eo; logic ec;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h80000001, 5'd1,  2'b00, 1'b0, 32'h00000002, 1'b1},  // R1 R6
    '{32'h80000001, 5'd1,  2'b01, 1'b0, 32'h40000000, 1'b1},  // R2 R6
    '{32'h80000000, 5'd4,  2'b10, 1'b0, 32'hF8000000, 1'b0},  // R3 R6
    '{32'h00000001, 5'd1,  2'b11, 1'b0, 32'h80000000, 1'b1},  // R4 R7
    '{32'h12345678, 5'd0,  2'b11, 1'b1, 32'h12345678, 1'b1},  // R5
    '{32'h12345678, 5'd4,  2'b11, 1'b0, 32'h81234567, 1'b1},  // R4 R7
    '{32'h7FFFFFFF, 5'd31, 2'b10, 1'b0, 32'h00000000, 1'b1},  // R3 R6
    '{32'hFFFFFFFF, 5'd31, 2'b00, 1'b0, 32'h80000000, 1'b1}   // R1 R6
  };

  function automatic string outTag(input logic [1:0] k, input logic [4:0] a);
    if (a == 0) return "R5";
    case (k)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string carryTag(input logic [1:0] k, input logic [4:0] a);
    if (a == 0) return "R5";
    return (k == 2'b11) ? "R7" : "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (d=%h a=%0d k=%0d)",
               tag, act, exp, dataIn, shiftAmt, shiftKind);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [4:0] a,
                       input logic [1:0] k, input logic ci);
    @(negedge clk);
    dataIn = d; shiftAmt = a; shiftKind = k; carryIn = ci;
    #2;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  localparam logic [31:0] PATS [4] = '{32'h8421F00D, 32'h5A3C96E1, 32'hFFFF0001, 32'h00000001};

  initial begin
    logic [31:0] expOut;
    logic        expC;
    // reset state: zero word with amount 0 passes through (R5)
    repeat (2) @(negedge clk);
    #2;
    check("R5", dataOut, 32'h0);
    check("R5", {31'b0, carryOut}, 32'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].d, VECS[v].a, VECS[v].k, VECS[v].ci);
      check(outTag(VECS[v].k, VECS[v].a), dataOut, VECS[v].eo);
      check(carryTag(VECS[v].k, VECS[v].a), {31'b0, carryOut}, {31'b0, VECS[v].ec});
    end

    // every kind, every amount, against operator references
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 32; a++) begin
          for (int ci = 0; ci < 2; ci++) begin
            if (a != 0 && ci == 1) continue;
            case (k)
              0: expOut = PATS[p] << a;
              1: expOut = PATS[p] >> a;
              2: expOut = 32'($signed(PATS[p]) >>> a);
              default: expOut = (a == 0) ? PATS[p] : ((PATS[p] >> a) | (PATS[p] << (32 - a)));
            endcase
            if (a == 0)      expC = ci[0];
            else if (k == 0) expC = PATS[p][32-a];
            else if (k == 3) expC = expOut[31];
            else             expC = PATS[p][a-1];
            apply(PATS[p], 5'(a), 2'(k), ci[0]);
            check(outTag(2'(k), 5'(a)), dataOut, expOut);
            check(carryTag(2'(k), 5'(a)), {31'b0, carryOut}, {31'b0, expC});
          end
        end
      end
    end
    finishRun();
  end
endmodule